// File: doc/BRIEF.md
# Reversible Looping Pattern Shifter

An eight-stage pattern register that advances one step on every rising edge of a slow gate clock. The gate clock is a plain level sampled in the system clock domain. The register can run toward stage 8 ("right") or toward stage 1 ("left"). Each rising edge on a toggle input reverses the running direction. The bit that enters the register is taken from a loop point that a 3-bit length code selects. When the direction reverses, the loop point moves to its mirrored stage, so a looped pattern keeps its length when it plays backwards.

An 8-bit chance value decides, at every step, what enters the register. The entering bit is either the loop-point bit, which repeats the pattern, or that bit XORed with an external data input, which brings in new material. The decision comes from comparing chance against a sample from an internal pseudo-random sequence. A write control overrides the entering bit with a forced level. Three views of the register are produced:
- a gate from stage 1 that is qualified by the gate clock;
- a 3-bit code from stages 1 to 3;
- an 8-bit code from all stages, with the opposite bit significance to the 3-bit code.

The direction logic is a two-state machine. In state ST_RIGHT the pattern moves from stage 1 toward stage 8. In state ST_LEFT it moves from stage 8 toward stage 1. The transition T_REVERSE_L goes from ST_RIGHT to ST_LEFT, and T_REVERSE_R goes from ST_LEFT to ST_RIGHT. Both are taken on a toggle rising edge. In any other cycle the machine stays in its state through T_HOLD.

Top module: `bidir_loop_shifter`

## Requirements
- R1: After a synchronous reset all stages are 0, both codes are 0, the gate is 0 and the direction is right (`dir_left` = 0).
- R2: The register changes only in a cycle where `bus_clk` is 1 and was 0 in the previous system clock cycle. Holding `bus_clk` high or low leaves all stages unchanged.
- R3: In the right direction, stage k+1 takes stage k and stage 1 takes the entering bit. In the left direction, stage k takes stage k+1 and stage 8 takes the entering bit.
- R4: Each rising edge of `dir_toggle` flips the direction once. Holding it high causes no further flips. `dir_left` is 1 while the direction is left.
- R5: Length code n (0 to 7) gives loop length n+1. In the right direction the loop point is stage n+1. In the left direction it is stage 8-n.
- R6: With chance = 255 and no write, the entering bit equals the loop-point bit.
- R7: With chance = 0 and no write, the entering bit equals the loop-point bit XOR `data_in`. For chance values in between, the entering bit is the loop-point bit when the 8-bit random sample is below chance.
- R8: While `wr_en` is 1, the entering bit is `wr_level`, whatever the chance and data.
- R9: A change of the length code alone does not alter any stage.
- R10: `gate_out` equals stage 1 AND `bus_clk`.
- R11: `code_narrow` bit 0 is stage 1 and bit 2 is stage 3. `code_wide` bit 7 is stage 1 and bit 0 is stage 8.
- R12: If a direction toggle edge and a shift edge fall in the same cycle, that shift uses the direction held before the toggle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_clk | input | 1 | Gate clock level; its rising edges advance the register |
| dir_toggle | input | 1 | Rising edge reverses the direction |
| len_sel | input | 3 | Length code n; loop length is n+1 |
| chance | input | 8 | Probability of looping; 255 always loops, 0 always injects |
| data_in | input | 1 | External data XORed into the loop bit |
| wr_en | input | 1 | Forces the entering bit while high |
| wr_level | input | 1 | Level forced by the write control |
| gate_out | output | 1 | Stage 1 qualified by the gate clock |
| code_narrow | output | 3 | Stages 1 to 3, stage 1 least significant |
| code_wide | output | 8 | All stages, stage 1 most significant |
| dir_left | output | 1 | 1 while the pattern runs toward stage 1 |

## Verification
The assertions assume that `bus_clk` and `dir_toggle` are already synchronous to `clk`. They also assume that each level lasts at least one system clock cycle, so that every edge is seen exactly once. The stimulus changes every input on the falling edge of `clk` and holds the gate clock high and low for whole cycles. Chance is held at 0 or 255 whenever the bench predicts the entering bit, because the random comparison for values in between is checked only by assertions.

// File: rtl/lsr_pkg.sv
package lsr_pkg;

    typedef enum logic {
        ST_RIGHT = 1'b0,
        ST_LEFT  = 1'b1
    } dir_state_t;

endpackage

// File: rtl/rise_detect.sv
module rise_detect (
    input  logic clk,
    input  logic rst,
    input  logic level,
    output logic rise
);
    logic level_q;

    always_ff @(posedge clk) begin
        if (rst) level_q <= 1'b0;
        else     level_q <= level;
    end

    assign rise = level & ~level_q;

    // R2: an edge is one cycle wide while the level is held
    assert_single_edge_R2: assert property (@(posedge clk) disable iff (rst)
        rise |=> !rise);
endmodule

// File: rtl/lfsr_gen.sv
module lfsr_gen #(
    parameter int          WIDTH = 16,
    parameter logic [15:0] TAPS  = 16'hB400,
    parameter logic [15:0] SEED  = 16'hACE1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             advance,
    output logic [WIDTH-1:0] value
);
    logic [WIDTH-1:0] state_q;
    logic [WIDTH-1:0] state_d;

    always_comb begin
        state_d = state_q;
        if (advance) begin
            if (state_q[0]) state_d = (state_q >> 1) ^ TAPS[WIDTH-1:0];
            else            state_d = state_q >> 1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= SEED[WIDTH-1:0];
        else     state_q <= state_d;
    end

    assign value = state_q;

    // R7: the random source never locks up at zero
    assert_lfsr_live_R7: assert property (@(posedge clk) disable iff (rst)
        state_q != '0);
endmodule

// File: rtl/entry_select.sv
module entry_select #(
    parameter int CH_W = 8
) (
    input  logic            loop_bit,
    input  logic            data_in,
    input  logic            wr_en,
    input  logic            wr_level,
    input  logic [CH_W-1:0] chance,
    input  logic [CH_W-1:0] sample,
    output logic            entry
);
    logic keep_loop;

    always_comb begin
        keep_loop = (&chance) | (sample < chance);
        if (wr_en)          entry = wr_level;
        else if (keep_loop) entry = loop_bit;
        else                entry = loop_bit ^ data_in;
    end
endmodule

// File: rtl/bidir_loop_shifter.sv
module bidir_loop_shifter #(
    parameter int STAGES = 8,
    parameter int LEN_W  = $clog2(STAGES),
    parameter int CH_W   = 8,
    parameter int NARROW = 3,
    parameter int RNG_W  = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_clk,
    input  logic              dir_toggle,
    input  logic [LEN_W-1:0]  len_sel,
    input  logic [CH_W-1:0]   chance,
    input  logic              data_in,
    input  logic              wr_en,
    input  logic              wr_level,
    output logic              gate_out,
    output logic [NARROW-1:0] code_narrow,
    output logic [STAGES-1:0] code_wide,
    output logic              dir_left
);
    import lsr_pkg::*;

    localparam int LAST = STAGES - 1;

    dir_state_t        state_q, state_d;
    logic [STAGES-1:0] stages;
    logic              bus_rise, dir_rise;
    logic              loop_bit, entry;
    logic [RNG_W-1:0]  rnd;
    logic [LEN_W-1:0]  loop_idx;

    rise_detect u_bus_edge (.clk(clk), .rst(rst), .level(bus_clk),    .rise(bus_rise));
    rise_detect u_dir_edge (.clk(clk), .rst(rst), .level(dir_toggle), .rise(dir_rise));

    lfsr_gen #(.WIDTH(RNG_W)) u_rng (
        .clk(clk), .rst(rst), .advance(bus_rise), .value(rnd)
    );

    // direction machine: T_REVERSE_L, T_REVERSE_R, T_HOLD
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RIGHT: if (dir_rise) state_d = ST_LEFT;
            ST_LEFT:  if (dir_rise) state_d = ST_RIGHT;
            default:  state_d = ST_RIGHT;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_RIGHT;
        else     state_q <= state_d;
    end

    // loop point mirrors with direction
    always_comb begin
        if (state_q == ST_LEFT) loop_idx = LEN_W'(LAST) - len_sel;
        else                    loop_idx = len_sel;
        loop_bit = stages[loop_idx];
    end

    entry_select #(.CH_W(CH_W)) u_entry (
        .loop_bit(loop_bit), .data_in(data_in), .wr_en(wr_en),
        .wr_level(wr_level), .chance(chance), .sample(rnd[CH_W-1:0]),
        .entry(entry)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            stages <= '0;
        end else if (bus_rise) begin
            unique case (state_q)
                ST_RIGHT: stages <= {stages[LAST-1:0], entry};
                ST_LEFT:  stages <= {entry, stages[LAST:1]};
                default:  stages <= stages;
            endcase
        end
    end

    // output views
    always_comb begin
        gate_out = stages[0] & bus_clk;
        dir_left = (state_q == ST_LEFT);
    end

    for (genvar i = 0; i < STAGES; i++) begin : g_wide
        assign code_wide[i] = stages[LAST-i];
    end
    for (genvar j = 0; j < NARROW; j++) begin : g_narrow
        assign code_narrow[j] = stages[j];
    end

    assert_hold_R2: assert property (@(posedge clk) disable iff (rst)
        !bus_rise |=> $stable(stages));
    assert_dir_flip_R4: assert property (@(posedge clk) disable iff (rst)
        dir_rise |=> (state_q != $past(state_q)));
    assert_loop_R6: assert property (@(posedge clk) disable iff (rst)
        (bus_rise && !wr_en && (&chance) && state_q == ST_RIGHT)
        |=> stages[0] == $past(loop_bit));
    assert_inject_R7: assert property (@(posedge clk) disable iff (rst)
        (bus_rise && !wr_en && chance == '0 && state_q == ST_RIGHT)
        |=> stages[0] == $past(loop_bit ^ data_in));
    assert_write_R8: assert property (@(posedge clk) disable iff (rst)
        (bus_rise && wr_en && state_q == ST_LEFT)
        |=> stages[LAST] == $past(wr_level));
    assert_prior_dir_R12: assert property (@(posedge clk) disable iff (rst)
        (bus_rise && state_q == ST_RIGHT && !wr_en && (&chance))
        |=> stages[LAST:1] == $past(stages[LAST-1:0]));
endmodule

// File: tb/bidir_loop_shifter_test.sv
module bidir_loop_shifter_test;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       bus_clk = 1'b0, dir_toggle = 1'b0;
    logic [2:0] len_sel = 3'd0;
    logic [7:0] chance = 8'd0;
    logic       data_in = 1'b0, wr_en = 1'b0, wr_level = 1'b0;
    logic       gate_out, dir_left;
    logic [2:0] code_narrow;
    logic [7:0] code_wide;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    bidir_loop_shifter uut (
        .clk(clk), .rst(rst), .bus_clk(bus_clk), .dir_toggle(dir_toggle),
        .len_sel(len_sel), .chance(chance), .data_in(data_in), .wr_en(wr_en),
        .wr_level(wr_level), .gate_out(gate_out), .code_narrow(code_narrow),
        .code_wide(code_wide), .dir_left(dir_left)
    );

    always #5 clk = ~clk;

    // {tog, wr, wlvl, chance[8], data, len[3], exp code_wide[8], exp dir_left}
    localparam logic [23:0] VECS [0:13] = '{
        {1'b0,1'b1,1'b1,8'd0,  1'b0,3'd0,8'h80,1'b0},  // R8 write high, R3 right
        {1'b0,1'b1,1'b1,8'd0,  1'b0,3'd0,8'hC0,1'b0},
        {1'b0,1'b1,1'b0,8'd0,  1'b0,3'd0,8'h60,1'b0},  // R8 write low
        {1'b0,1'b0,1'b0,8'd255,1'b0,3'd2,8'hB0,1'b0},  // R6 R5 loop stage 3
        {1'b0,1'b0,1'b0,8'd255,1'b0,3'd2,8'hD8,1'b0},
        {1'b0,1'b0,1'b0,8'd0,  1'b1,3'd2,8'hEC,1'b0},  // R7 inject
        {1'b0,1'b0,1'b0,8'd0,  1'b1,3'd7,8'hF6,1'b0},  // R5 loop stage 8
        {1'b1,1'b0,1'b0,8'd255,1'b0,3'd0,8'hFB,1'b1},  // R12 toggle with shift
        {1'b0,1'b0,1'b0,8'd255,1'b0,3'd0,8'hF7,1'b1},  // R5 left mirror stage 8
        {1'b0,1'b1,1'b0,8'd0,  1'b0,3'd0,8'hEE,1'b1},  // R3 left
        {1'b0,1'b0,1'b0,8'd0,  1'b0,3'd2,8'hDD,1'b1},  // R5 left stage 6
        {1'b0,1'b0,1'b0,8'd0,  1'b1,3'd2,8'hBA,1'b1},  // R7 left
        {1'b1,1'b1,1'b1,8'd0,  1'b0,3'd2,8'h75,1'b0},  // R12 left then right
        {1'b0,1'b0,1'b0,8'd255,1'b0,3'd4,8'h3A,1'b0}   // R6 stage 5
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic report();
        if (!finished) begin
            finished = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        #2_000_000;
        errors++;
        $display("FAIL watchdog: actual hung expected done");
        report();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R1 code_wide", 32'(code_wide), 32'h0);
        check("R1 code_narrow", 32'(code_narrow), 32'h0);
        check("R1 dir_left", 32'(dir_left), 32'h0);
        check("R1 gate_out", 32'(gate_out), 32'h0);

        for (int v = 0; v < 14; v++) begin
            logic [23:0] e;
            e = VECS[v];
            dir_toggle = e[23]; wr_en = e[22]; wr_level = e[21];
            chance = e[20:13]; data_in = e[12]; len_sel = e[11:9];
            bus_clk = 1'b1;
            @(negedge clk);
            check($sformatf("R3/R5-R8 vec %0d code_wide", v), 32'(code_wide), 32'(e[8:1]));
            check($sformatf("R11 vec %0d code_narrow", v), 32'(code_narrow),
                  32'({e[6], e[7], e[8]}));
            check($sformatf("R10 vec %0d gate high", v), 32'(gate_out), 32'(e[8]));
            bus_clk = 1'b0; dir_toggle = 1'b0;
            @(negedge clk);
            check($sformatf("R4/R12 vec %0d dir_left", v), 32'(dir_left), 32'(e[0]));
            check($sformatf("R10 vec %0d gate low", v), 32'(gate_out), 32'h0);
        end

        // R2: held-high gate clock shifts once only
        wr_en = 1'b1; wr_level = 1'b1; chance = 8'd255; bus_clk = 1'b1;
        repeat (4) @(negedge clk);
        check("R2 held high single shift", 32'(code_wide), 32'h9D);
        bus_clk = 1'b0; wr_en = 1'b0;
        repeat (3) @(negedge clk);
        check("R2 held low no shift", 32'(code_wide), 32'h9D);

        // R9: length change alone leaves the stages intact
        len_sel = 3'd7;
        repeat (2) @(negedge clk);
        len_sel = 3'd1;
        repeat (2) @(negedge clk);
        check("R9 length change", 32'(code_wide), 32'h9D);

        // R4: held toggle flips once
        dir_toggle = 1'b1;
        repeat (4) @(negedge clk);
        check("R4 held toggle", 32'(dir_left), 32'h1);
        dir_toggle = 1'b0;
        repeat (2) @(negedge clk);
        check("R4 after release", 32'(dir_left), 32'h1);
        check("R4 no shift from toggle", 32'(code_wide), 32'h9D);

        // R1: reset mid-run
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R1 mid reset code_wide", 32'(code_wide), 32'h0);
        check("R1 mid reset dir_left", 32'(dir_left), 32'h0);
        check("R1 mid reset code_narrow", 32'(code_narrow), 32'h0);

        report();
    end
endmodule